// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block translates addresses arriving from an external link into internal fabric requests. Software programs a bank of address windows through a word-wide register port. There are five windows placed at a regular stride and one extra window with its own registers. Each window has a base, a size mask, a remap value, an attribute byte and a target ID. A single aperture register pair sits in front of the whole bank. It is sized by software to the sum of the window sizes rounded up to a power of two. An address that falls outside the aperture is rejected before any window is considered.

For each lookup the block compares the address against every window in parallel. It picks the lowest-numbered window that matches and reports one cycle later whether it hit or missed. On a hit it also reports the window index, target ID, attribute byte and translated address. On a miss the target, attribute and index are zero and the address passes through unchanged.

Top module: `iwin_decode`

## Requirements
- R1: After reset every window and aperture register reads zero, and every lookup reports a miss.
- R2: A window control word keeps size-minus-one in bits 31:16, attribute in bits 15:8, target ID in bits 7:4 and enable in bit 0, and reads bits 3:1 as zero. Base and remap registers keep bits 31:16 and read bits 15:0 as zero.
- R3: Window n (n = 0..4) has control at 0x1820+16n, base at 0x1824+16n and remap at 0x182C+16n. The extra window (index 5) uses 0x1880, 0x1884 and 0x188C. The aperture base is at 0x1800 (bits 31:16 kept) and the aperture control is at 0x1804 (size-minus-one in 31:16, enable in bit 0).
- R4: A window matches when it is enabled and the address bits above its mask equal its base bits above the mask. The mask is the size field followed by sixteen one bits.
- R5: On a hit the output address is the remap bits above the mask combined with the lookup address bits inside the mask.
- R6: On a hit the output target ID and attribute byte are those of the selected window, and the output index is that window's number.
- R7: When several windows match, the one with the lowest index is selected.
- R8: A lookup address outside the aperture, or any lookup while the aperture is disabled, is a miss even if a window matches.
- R9: Results appear on the clock after the lookup is presented. The output valid flag follows the lookup valid flag and exactly one of hit and miss is set. A miss reports zero target, attribute and index with the lookup address passed through. With no lookup, all outputs are zero.
- R10: A window with its enable bit cleared never matches, so a lower-priority overlapping window takes over.
- R11: Register writes to offsets that are not mapped have no effect and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (13) | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup address |
| out_valid | output | 1 | Result valid, one cycle after lk_valid |
| out_hit | output | 1 | Lookup matched a window inside the aperture |
| out_miss | output | 1 | Lookup matched nothing usable |
| out_win | output | IDX_W (3) | Index of the selected window |
| out_target | output | 4 | Target ID of the selected window |
| out_attr | output | 8 | Attribute byte of the selected window |
| out_addr | output | 32 | Translated address, or the lookup address on a miss |

## Verification
Several properties are checked on every cycle: the one-cycle valid relation, that hit and miss never both assert, that miss results carry zero target and attribute with the address passed through, and that a disabled aperture never yields a hit. Other behaviours can only be shown by the bench's scenarios. These are the per-window compare arithmetic, the remap splice at mask boundaries, lowest-index priority among overlapping windows, field masking on register writes, the offset map and the handling of unmapped writes. The bench has to program known windows and compare the results against values worked out by hand.

// File: rtl/iwin_pkg.sv
// Shared types for the inbound window decoder.
// Assumes a 32-bit address space with 64 KiB window granularity.
package iwin_pkg;

    // Fields of one window control word, held compactly.
    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic        en;
    } win_ctrl_t;

    // Full stored state of one window.
    typedef struct packed {
        win_ctrl_t   ctrl;
        logic [15:0] base_hi;
        logic [15:0] remap_hi;
    } win_cfg_t;

endpackage

// File: rtl/iwin_regs.sv
// Register file for the window bank and the aperture.
// Stores only the architected bits and returns zero for unmapped offsets.
// Assumes word-aligned 32-bit accesses; reads are combinational.
module iwin_regs
    import iwin_pkg::*;
#(
    parameter int NUM_IDX_WIN   = 5,
    parameter int REG_AW        = 13,
    parameter int IDX_CTRL_OFS  = 'h1820,
    parameter int IDX_STRIDE    = 16,
    parameter int XTRA_CTRL_OFS = 'h1880,
    parameter int BAR_BASE_OFS  = 'h1800,
    parameter int BAR_CTRL_OFS  = 'h1804,
    localparam int NUM_WIN      = NUM_IDX_WIN + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output win_cfg_t [NUM_WIN-1:0] cfg,
    output logic [15:0]           bar_base_hi,
    output logic [15:0]           bar_size_m1,
    output logic                  bar_en
);

    localparam int BASE_DELTA  = 4;
    localparam int REMAP_DELTA = 12;

    // Control-register offset of window w.
    function automatic int ctrl_ofs(input int w);
        return (w < NUM_IDX_WIN) ? IDX_CTRL_OFS + w * IDX_STRIDE : XTRA_CTRL_OFS;
    endfunction

    logic unused_wbits;
    assign unused_wbits = ^wdata[3:1];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int C_OFS = ctrl_ofs(w);
        win_cfg_t q;

        // Capture writes aimed at this window's three registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en) begin
                if (addr == REG_AW'(C_OFS)) begin
                    q.ctrl.size_m1 <= wdata[31:16];
                    q.ctrl.attr    <= wdata[15:8];
                    q.ctrl.target  <= wdata[7:4];
                    q.ctrl.en      <= wdata[0];
                end
                if (addr == REG_AW'(C_OFS + BASE_DELTA))  q.base_hi  <= wdata[31:16];
                if (addr == REG_AW'(C_OFS + REMAP_DELTA)) q.remap_hi <= wdata[31:16];
            end
        end

        assign cfg[w] = q;
    end

    // Capture writes aimed at the aperture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_base_hi <= '0;
            bar_size_m1 <= '0;
            bar_en      <= 1'b0;
        end else if (wr_en) begin
            if (addr == REG_AW'(BAR_BASE_OFS)) bar_base_hi <= wdata[31:16];
            if (addr == REG_AW'(BAR_CTRL_OFS)) begin
                bar_size_m1 <= wdata[31:16];
                bar_en      <= wdata[0];
            end
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == REG_AW'(BAR_BASE_OFS)) rdata = {bar_base_hi, 16'h0};
        if (addr == REG_AW'(BAR_CTRL_OFS)) rdata = {bar_size_m1, 15'h0, bar_en};
        for (int w = 0; w < NUM_WIN; w++) begin
            if (addr == REG_AW'(ctrl_ofs(w)))
                rdata = {cfg[w].ctrl.size_m1, cfg[w].ctrl.attr,
                         cfg[w].ctrl.target, 3'b000, cfg[w].ctrl.en};
            if (addr == REG_AW'(ctrl_ofs(w) + BASE_DELTA))
                rdata = {cfg[w].base_hi, 16'h0};
            if (addr == REG_AW'(ctrl_ofs(w) + REMAP_DELTA))
                rdata = {cfg[w].remap_hi, 16'h0};
        end
    end

endmodule

// File: rtl/iwin_match.sv
// Compare and translate stage for one window.
// Assumes the size field is contiguous ones from the bottom (size is a power of two).
module iwin_match (
    input  logic [31:0] addr,
    input  logic        en,
    input  logic [15:0] size_m1,
    input  logic [15:0] base_hi,
    input  logic [15:0] remap_hi,
    output logic        hit,
    output logic [31:0] mapped
);

    logic [31:0] mask;

    // Build the in-window mask, test the upper bits and splice the remap.
    always_comb begin
        mask   = {size_m1, 16'hFFFF};
        hit    = en && ((addr & ~mask) == ({base_hi, 16'h0} & ~mask));
        mapped = ({remap_hi, 16'h0} & ~mask) | (addr & mask);
    end

endmodule

// File: rtl/iwin_prio.sv
// Fixed-priority select: the lowest set bit of the hit vector wins.
module iwin_prio #(
    parameter int NUM_WIN = 6,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        any = |hit_vec;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--)
            if (hit_vec[i]) idx = IDX_W'(i);
    end

endmodule

// File: rtl/iwin_decode.sv
// Inbound address window decoder top.
// Holds the register bank, compares every window in parallel, gates the result
// with the aperture and registers the selected result (one cycle latency).
// Assumes lookups and register writes may occur in the same cycle; a lookup
// always sees the register values from before that cycle's write.
module iwin_decode
    import iwin_pkg::*;
#(
    parameter int NUM_IDX_WIN   = 5,
    parameter int REG_AW        = 13,
    parameter int IDX_CTRL_OFS  = 'h1820,
    parameter int IDX_STRIDE    = 16,
    parameter int XTRA_CTRL_OFS = 'h1880,
    parameter int BAR_BASE_OFS  = 'h1800,
    parameter int BAR_CTRL_OFS  = 'h1804,
    localparam int NUM_WIN      = NUM_IDX_WIN + 1,
    localparam int IDX_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_miss,
    output logic [IDX_W-1:0]  out_win,
    output logic [3:0]        out_target,
    output logic [7:0]        out_attr,
    output logic [31:0]       out_addr
);

    win_cfg_t [NUM_WIN-1:0]     cfg;
    logic [15:0]                bar_base_hi;
    logic [15:0]                bar_size_m1;
    logic                       bar_en;
    logic [NUM_WIN-1:0]         hit_vec;
    logic [NUM_WIN-1:0][31:0]   mapped;
    logic                       any_hit;
    logic [IDX_W-1:0]           sel;
    logic                       in_bar;
    logic                       final_hit;
    logic [31:0]                bar_mask;

    iwin_regs #(
        .NUM_IDX_WIN  (NUM_IDX_WIN),
        .REG_AW       (REG_AW),
        .IDX_CTRL_OFS (IDX_CTRL_OFS),
        .IDX_STRIDE   (IDX_STRIDE),
        .XTRA_CTRL_OFS(XTRA_CTRL_OFS),
        .BAR_BASE_OFS (BAR_BASE_OFS),
        .BAR_CTRL_OFS (BAR_CTRL_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .cfg        (cfg),
        .bar_base_hi(bar_base_hi),
        .bar_size_m1(bar_size_m1),
        .bar_en     (bar_en)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        iwin_match u_match (
            .addr    (lk_addr),
            .en      (cfg[w].ctrl.en),
            .size_m1 (cfg[w].ctrl.size_m1),
            .base_hi (cfg[w].base_hi),
            .remap_hi(cfg[w].remap_hi),
            .hit     (hit_vec[w]),
            .mapped  (mapped[w])
        );
    end

    iwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hit_vec(hit_vec),
        .any    (any_hit),
        .idx    (sel)
    );

    // Aperture gate: the address must lie inside the enabled aperture.
    always_comb begin
        bar_mask  = {bar_size_m1, 16'hFFFF};
        in_bar    = bar_en && ((lk_addr & ~bar_mask) == ({bar_base_hi, 16'h0} & ~bar_mask));
        final_hit = any_hit && in_bar;
    end

    // Register the selected result; everything is zero without a lookup.
    always_ff @(posedge clk) begin
        if (!rst_n || !lk_valid) begin
            out_valid  <= 1'b0;
            out_hit    <= 1'b0;
            out_miss   <= 1'b0;
            out_win    <= '0;
            out_target <= '0;
            out_attr   <= '0;
            out_addr   <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_hit    <= final_hit;
            out_miss   <= !final_hit;
            out_win    <= final_hit ? sel : '0;
            out_target <= final_hit ? cfg[sel].ctrl.target : 4'h0;
            out_attr   <= final_hit ? cfg[sel].ctrl.attr : 8'h0;
            out_addr   <= final_hit ? mapped[sel] : lk_addr;
        end
    end

endmodule

// File: rtl/iwin_decode_chk.sv
// Property checker for iwin_decode, attached by bind.
// Keeps its own shadow of the aperture enable, built from register writes.
module iwin_decode_chk #(
    parameter int NUM_WIN      = 6,
    parameter int REG_AW       = 13,
    parameter int BAR_CTRL_OFS = 'h1804,
    parameter int IDX_W        = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wdata_b0,
    input logic              lk_valid,
    input logic [31:0]       lk_addr,
    input logic              out_valid,
    input logic              out_hit,
    input logic              out_miss,
    input logic [IDX_W-1:0]  out_win,
    input logic [3:0]        out_target,
    input logic [7:0]        out_attr,
    input logic [31:0]       out_addr
);

    logic bar_en_sh;

    // Shadow of the aperture enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bar_en_sh <= 1'b0;
        else if (reg_wr_en && reg_addr == REG_AW'(BAR_CTRL_OFS)) bar_en_sh <= reg_wdata_b0;
    end

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> out_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!out_valid && !out_hit && !out_miss));
    p_hit_miss_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_miss));
    p_miss_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_target == 4'h0 && out_attr == 8'h0 && out_win == '0 &&
                      out_addr == $past(lk_addr)));
    p_bar_off_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !bar_en_sh) |=> !out_hit);
    p_win_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (int'(out_win) < NUM_WIN));

endmodule

bind iwin_decode iwin_decode_chk #(
    .NUM_WIN     (NUM_WIN),
    .REG_AW      (REG_AW),
    .BAR_CTRL_OFS(BAR_CTRL_OFS),
    .IDX_W       (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata_b0(reg_wdata[0]),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .out_valid   (out_valid),
    .out_hit     (out_hit),
    .out_miss    (out_miss),
    .out_win     (out_win),
    .out_target  (out_target),
    .out_attr    (out_attr),
    .out_addr    (out_addr)
);

// File: tb/iwin_decode_bench.sv
`timescale 1ns/1ps
// Self-checking bench: programs six windows and the aperture, walks a vector
// table of lookups, then runs directed reset and corner-case tests.
module iwin_decode_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [2:0]  out_win;
    logic [3:0]  out_target;
    logic [7:0]  out_attr;
    logic [31:0] out_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iwin_decode u_iwin_decode (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win),
        .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr)
    );

    // {addr, hit, win, target, attr, expected out_addr}
    localparam int NVEC = 12;
    localparam logic [79:0] VEC [NVEC] = '{
        {32'h8123_4567, 1'b1, 3'd0, 4'h0, 8'h0E, 32'h0123_4567},
        {32'h9ABC_DEF0, 1'b1, 3'd1, 4'h2, 8'h0D, 32'h1ABC_DEF0},
        {32'hA000_1234, 1'b1, 3'd3, 4'h3, 8'h07, 32'h2000_1234},
        {32'hA020_0000, 1'b1, 3'd4, 4'h4, 8'h09, 32'h3020_0000},
        {32'hB000_ABCD, 1'b1, 3'd5, 4'h7, 8'h06, 32'hC000_ABCD},
        {32'hB001_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'hB001_0000},
        {32'hC000_0010, 1'b0, 3'd0, 4'h0, 8'h00, 32'hC000_0010},
        {32'h7FFF_FFFF, 1'b0, 3'd0, 4'h0, 8'h00, 32'h7FFF_FFFF},
        {32'hBFFF_FFFF, 1'b0, 3'd0, 4'h0, 8'h00, 32'hBFFF_FFFF},
        {32'h8FFF_FFFF, 1'b1, 3'd0, 4'h0, 8'h0E, 32'h0FFF_FFFF},
        {32'h9000_0000, 1'b1, 3'd1, 4'h2, 8'h0D, 32'h1000_0000},
        {32'hA0FF_FFFF, 1'b1, 3'd4, 4'h4, 8'h09, 32'h30FF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Present one lookup; results are sampled at the negedge after the capturing posedge.
    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic hit, input logic [2:0] win,
                                 input logic [3:0] tgt, input logic [7:0] attr, input logic [31:0] oa);
        check({req, " valid"}, {31'h0, out_valid}, 32'h1);
        check({req, " hit"},   {31'h0, out_hit},   {31'h0, hit});
        check({req, " miss"},  {31'h0, out_miss},  {31'h0, !hit});
        check({req, " win"},   {29'h0, out_win},   {29'h0, win});
        check({req, " target"},{28'h0, out_target},{28'h0, tgt});
        check({req, " attr"},  {24'h0, out_attr},  {24'h0, attr});
        check({req, " addr"},  out_addr, oa);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset, and lookups miss.
        for (int w = 0; w < 5; w++) begin
            rd(13'(32'h1820 + 16 * w), v); check("R1 ctrl", v, 0);
            rd(13'(32'h1824 + 16 * w), v); check("R1 base", v, 0);
            rd(13'(32'h182C + 16 * w), v); check("R1 remap", v, 0);
        end
        rd(13'h1880, v); check("R1 xtra ctrl", v, 0);
        rd(13'h1884, v); check("R1 xtra base", v, 0);
        rd(13'h188C, v); check("R1 xtra remap", v, 0);
        rd(13'h1800, v); check("R1 bar base", v, 0);
        rd(13'h1804, v); check("R1 bar ctrl", v, 0);
        lookup(32'h8000_0000);
        expect_result("R1 reset lookup", 1'b0, 3'd0, 4'h0, 8'h00, 32'h8000_0000);

        // R2: field masking on stored words.
        wr(13'h1820, 32'hFFFF_FFFF); rd(13'h1820, v); check("R2 ctrl fields", v, 32'hFFFF_FFF1);
        wr(13'h1824, 32'hFFFF_FFFF); rd(13'h1824, v); check("R2 base low bits", v, 32'hFFFF_0000);
        wr(13'h182C, 32'h1234_5678); rd(13'h182C, v); check("R2 remap low bits", v, 32'h1234_0000);

        // Program the bank: aperture 0x8000_0000 size 1 GiB.
        wr(13'h1800, 32'h8000_0000); wr(13'h1804, 32'h3FFF_0001);
        wr(13'h1820, 32'h0FFF_0E01); wr(13'h1824, 32'h8000_0000); wr(13'h182C, 32'h0000_0000);
        wr(13'h1830, 32'h0FFF_0D21); wr(13'h1834, 32'h9000_0000); wr(13'h183C, 32'h1000_0000);
        wr(13'h1840, 32'h0000_0B51); wr(13'h1844, 32'hC000_0000); wr(13'h184C, 32'h4000_0000);
        wr(13'h1850, 32'h000F_0731); wr(13'h1854, 32'hA000_0000); wr(13'h185C, 32'h2000_0000);
        wr(13'h1860, 32'h00FF_0941); wr(13'h1864, 32'hA000_0000); wr(13'h186C, 32'h3000_0000);
        wr(13'h1880, 32'h0000_0671); wr(13'h1884, 32'hB000_0000); wr(13'h188C, 32'hC000_0000);

        // R3: offset map readback.
        rd(13'h1880, v); check("R3 xtra ctrl", v, 32'h0000_0671);
        rd(13'h186C, v); check("R3 win4 remap", v, 32'h3000_0000);
        rd(13'h1834, v); check("R3 win1 base", v, 32'h9000_0000);
        rd(13'h1804, v); check("R3 bar ctrl", v, 32'h3FFF_0001);

        // R4 R5 R6 R7 R8: vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            lookup(VEC[i][79:48]);
            expect_result($sformatf("R4 R5 R6 R7 R8 vector %0d", i),
                          VEC[i][47], VEC[i][46:44], VEC[i][43:40], VEC[i][39:32], VEC[i][31:0]);
        end

        // R9: idle cycle yields quiet outputs.
        @(negedge clk);
        check("R9 idle valid", {31'h0, out_valid}, 0);
        check("R9 idle hit/miss", {30'h0, out_hit, out_miss}, 0);
        check("R9 idle addr", out_addr, 0);

        // R11: unmapped writes are ignored.
        wr(13'h1828, 32'hDEAD_BEEF); rd(13'h1828, v); check("R11 gap read", v, 0);
        wr(13'h1890, 32'hDEAD_BEEF); rd(13'h1890, v); check("R11 past end read", v, 0);
        lookup(32'h8123_4567);
        expect_result("R11 decode unchanged", 1'b1, 3'd0, 4'h0, 8'h0E, 32'h0123_4567);

        // R10: disabling window 3 hands its range to window 4.
        wr(13'h1850, 32'h000F_0730);
        lookup(32'hA000_1234);
        expect_result("R10 disabled window", 1'b1, 3'd4, 4'h4, 8'h09, 32'h3000_1234);
        wr(13'h1850, 32'h000F_0731);
        lookup(32'hA000_1234);
        expect_result("R10 re-enabled", 1'b1, 3'd3, 4'h3, 8'h07, 32'h2000_1234);

        // R8: aperture disabled turns every lookup into a miss.
        wr(13'h1804, 32'h3FFF_0000);
        lookup(32'h8123_4567);
        expect_result("R8 aperture off", 1'b0, 3'd0, 4'h0, 8'h00, 32'h8123_4567);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule